// File: doc/BRIEF.md
# Serial Configuration Slave with Burst Auto-Increment

This block is a write-only slave for a three-wire serial port: an active-low frame strobe, a bit clock and a data line. The three pins are synchronised into the system clock, and a small frame state machine turns them into 12-bit register writes. A frame carries a 3-bit start address, one guard bit and then any number of 12-bit words. Each word goes to the next address. Written words wait in shadow registers and reach the outputs together when the strobe rises.

The block holds four live registers: an operating register, a pin-control register, a black-clamp level and an amplifier gain. It exports their decoded fields directly. Setting bit 0 of the operating register restores every register to its default. For a configurable number of system clocks after reset, while the downstream circuitry calibrates, completed words are dropped.

The frame state machine has four states. F_IDLE waits for the strobe to go low, then moves to F_ADDR. F_ADDR collects three address bits and moves to F_TEST after the third. F_TEST takes the guard bit and moves to F_DATA. F_DATA shifts words, steps the address after each twelfth bit and stays there. From F_ADDR, F_TEST or F_DATA, a rising strobe returns the machine to F_IDLE and commits the frame.

Top module: `ser_cfg_slave`

## Requirements
- R1: After reset every field reads zero, except the clamp level, which reads 128.
- R2: While the strobe is low, the data line is sampled on each rising bit clock. The order is address bit 0, bit 1, bit 2, then the guard bit, then data bit 0 up to data bit 11, least significant first. A complete word is written to the addressed register.
- R3: Operating register (address 0): bits 2:1 drive the power mode (00 normal, 01 standby, 10 shutdown). Bit 3 drives clamp disable and bit 6 drives blank-to-clamp-level.
- R4: Control register (address 1): bit 0 sets sample-clock polarity, bit 1 output-latch-clock polarity, bit 2 clamp-pulse polarity and bit 3 blanking polarity. Bit 4 drives output high-impedance, bit 5 latch transparency and bit 6 Gray coding.
- R5: Address 2 bits 7:0 give the clamp level. Address 3 bits 9:0 give the gain.
- R6: Outputs do not change until the strobe rises. All words of a frame then take effect together, three system clocks after the rising strobe reaches the pin.
- R7: After each complete word the address advances by one, wrapping from 7 to 0. Words sent to addresses 4 to 7 have no effect.
- R8: If the guard bit of a frame is 1, none of that frame's words have any effect.
- R9: A word that is still incomplete when the strobe rises is discarded.
- R10: Committing an operating-register word with bit 0 set returns every register to its reset value. This includes words written in the same frame.
- R11: A word completed within the first CAL_CYCLES system clocks after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_load_n | input | 1 | Frame strobe, low during a frame |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data |
| pwr_mode | output | 2 | Power mode field |
| clamp_off | output | 1 | Black clamp disable |
| blank_to_clamp | output | 1 | Blank to clamp level instead of zero |
| pol_sample | output | 1 | Sample-clock polarity |
| pol_dclk | output | 1 | Output-latch-clock polarity |
| pol_clamp | output | 1 | Clamp-pulse polarity |
| pol_blank | output | 1 | Blanking polarity |
| out_hiz | output | 1 | Output high-impedance request |
| latch_transparent | output | 1 | Output latch transparent |
| gray_out | output | 1 | Gray-coded output |
| clamp_level | output | 8 | Black clamp level |
| vga_gain | output | 10 | Amplifier gain code |

## Verification
The hardest cases from the ports are a burst that starts at address 6, so that two ignored words come before the wrap to 0, and a frame cut off mid-word. In the cut-off frame, the discarded bits would otherwise have landed in a register that can be observed. The bench shifts these frames bit by bit with a slow bit clock, so every synchroniser edge is seen. Its reference model keeps its own shadow copies and applies them exactly three clocks after each rising strobe. Every field is therefore compared on every clock, including the cycles between the last bit and the commit.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
    localparam int WORD_W   = 12;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 4;
    localparam int CLAMP_IX = 2;
    localparam int CLAMP_RST = 128;

    typedef enum logic [1:0] {F_IDLE, F_ADDR, F_TEST, F_DATA} frame_st_t;

    function automatic logic [WORD_W-1:0] reg_default(input int idx);
        return (idx == CLAMP_IX) ? WORD_W'(CLAMP_RST) : '0;
    endfunction
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] pin_s,
    output logic [N-1:0] pin_d
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              last_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[i]}};
                last_q  <= RST_VAL[i];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin[i]};
                last_q  <= chain_q[STAGES-1];
            end
        end
        assign pin_s[i] = chain_q[STAGES-1];
        assign pin_d[i] = last_q;
    end
endmodule

// File: rtl/ser_cfg_frame.sv
module ser_cfg_frame
    import ser_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sl_s,
    input  logic              sl_rise,
    input  logic              sck_rise,
    input  logic              sd_s,
    output logic              word_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_word,
    output logic              commit
);
    localparam int CNT_W = $clog2(WORD_W);

    frame_st_t         st_q, st_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              guard_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            F_IDLE: if (!sl_s) st_nxt = F_ADDR;
            F_ADDR: begin
                if (sl_rise) st_nxt = F_IDLE;
                else if (sck_rise && cnt_q == CNT_W'(ADDR_W-1)) st_nxt = F_TEST;
            end
            F_TEST: begin
                if (sl_rise) st_nxt = F_IDLE;
                else if (sck_rise) st_nxt = F_DATA;
            end
            F_DATA: if (sl_rise) st_nxt = F_IDLE;
        endcase
    end

    always_comb begin
        commit   = sl_rise && (st_q != F_IDLE);
        word_stb = (st_q == F_DATA) && sck_rise && !sl_rise &&
                   (cnt_q == CNT_W'(WORD_W-1)) && !guard_q;
        wr_word  = {sd_s, data_q[WORD_W-1:1]};
        wr_addr  = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            guard_q <= 1'b0;
        end else if (sl_rise || st_q == F_IDLE) begin
            cnt_q <= '0;
        end else if (sck_rise) begin
            unique case (st_q)
                F_ADDR: begin
                    addr_q <= {sd_s, addr_q[ADDR_W-1:1]};
                    cnt_q  <= (cnt_q == CNT_W'(ADDR_W-1)) ? '0 : cnt_q + 1'b1;
                end
                F_TEST: begin
                    guard_q <= sd_s;
                    cnt_q   <= '0;
                end
                F_DATA: begin
                    data_q <= {sd_s, data_q[WORD_W-1:1]};
                    if (cnt_q == CNT_W'(WORD_W-1)) begin
                        cnt_q  <= '0;
                        addr_q <= addr_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                F_IDLE: cnt_q <= '0;
            endcase
        end
    end

    assert_word_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> !sl_s);
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));
    assert_partial_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sl_rise |=> (st_q == F_IDLE));
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
    import ser_cfg_pkg::*;
#(
    parameter int CAL_CYCLES = 40000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             word_stb,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [WORD_W-1:0]                wr_word,
    input  logic                             commit,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  live_q
);
    localparam int CW = $clog2(CAL_CYCLES + 1) + 1;

    logic [CW-1:0]                    cal_q;
    logic                             cal_done;
    logic [NUM_REGS-1:0][WORD_W-1:0]  shadow_q;
    logic [NUM_REGS-1:0][WORD_W-1:0]  dflt;
    logic [NUM_REGS-1:0]              pend_q;
    logic                             sreset;

    assign cal_done = (cal_q == CW'(CAL_CYCLES));
    assign sreset   = commit && pend_q[0] && shadow_q[0][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cal_q <= '0;
        else if (!cal_done) cal_q <= cal_q + 1'b1;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign dflt[i] = reg_default(i);
        assign hit     = word_stb && cal_done && (wr_addr == ADDR_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q[i]   <= reg_default(i);
                shadow_q[i] <= '0;
                pend_q[i]   <= 1'b0;
            end else if (commit) begin
                pend_q[i] <= 1'b0;
                if (sreset)         live_q[i] <= dflt[i];
                else if (pend_q[i]) live_q[i] <= shadow_q[i];
            end else if (hit) begin
                shadow_q[i] <= wr_word;
                pend_q[i]   <= 1'b1;
            end
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_q));
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && pend_q[0] && shadow_q[0][0]) |=> (live_q == dflt));
    assert_cal_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> (pend_q == '0));
endmodule

// File: rtl/ser_cfg_slave.sv
module ser_cfg_slave
    import ser_cfg_pkg::*;
#(
    parameter int CAL_CYCLES  = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_load_n,
    input  logic       ser_clk,
    input  logic       ser_data,
    output logic [1:0] pwr_mode,
    output logic       clamp_off,
    output logic       blank_to_clamp,
    output logic       pol_sample,
    output logic       pol_dclk,
    output logic       pol_clamp,
    output logic       pol_blank,
    output logic       out_hiz,
    output logic       latch_transparent,
    output logic       gray_out,
    output logic [7:0] clamp_level,
    output logic [9:0] vga_gain
);
    logic [2:0] pin_s, pin_d;
    logic       sl_rise, sck_rise;
    logic       word_stb, commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_word;
    logic [NUM_REGS-1:0][WORD_W-1:0] live;
    logic unused_bits;

    ser_cfg_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .pin({ser_data, ser_clk, ser_load_n}),
        .pin_s(pin_s), .pin_d(pin_d));

    assign sl_rise  = pin_s[0] && !pin_d[0];
    assign sck_rise = pin_s[1] && !pin_d[1];

    ser_cfg_frame i_frame (
        .clk(clk), .rst_n(rst_n), .sl_s(pin_s[0]), .sl_rise(sl_rise),
        .sck_rise(sck_rise), .sd_s(pin_s[2]), .word_stb(word_stb),
        .wr_addr(wr_addr), .wr_word(wr_word), .commit(commit));

    ser_cfg_regs #(.CAL_CYCLES(CAL_CYCLES)) i_regs (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .wr_addr(wr_addr),
        .wr_word(wr_word), .commit(commit), .live_q(live));

    assign pwr_mode          = live[0][2:1];
    assign clamp_off         = live[0][3];
    assign blank_to_clamp    = live[0][6];
    assign pol_sample        = live[1][0];
    assign pol_dclk          = live[1][1];
    assign pol_clamp         = live[1][2];
    assign pol_blank         = live[1][3];
    assign out_hiz           = live[1][4];
    assign latch_transparent = live[1][5];
    assign gray_out          = live[1][6];
    assign clamp_level       = live[2][7:0];
    assign vga_gain          = live[3][9:0];
    assign unused_bits = ^{live[0][11:7], live[0][5:4], live[0][0], live[1][11:7],
                           live[2][11:8], live[3][11:10], pin_d[2]};
endmodule

// File: tb/test_ser_cfg_slave.sv
module test_ser_cfg_slave;
    localparam int CAL = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sl = 1'b1, sck = 1'b0, sdata = 1'b0;
    logic [1:0] pwr_mode;
    logic clamp_off, blank_to_clamp, pol_sample, pol_dclk, pol_clamp, pol_blank;
    logic out_hiz, latch_transparent, gray_out;
    logic [7:0] clamp_level;
    logic [9:0] vga_gain;

    int checks = 0, fails = 0;
    bit checking = 0, done = 0;
    string cur_req = "R1";
    logic [11:0] mreg [4];
    logic [11:0] msh [4];
    bit          mpd [4];
    logic [11:0] wq [$];

    always #2 clk = ~clk;

    ser_cfg_slave #(.CAL_CYCLES(CAL)) i_ser_cfg_slave (
        .clk(clk), .rst_n(rst_n), .ser_load_n(sl), .ser_clk(sck), .ser_data(sdata),
        .pwr_mode(pwr_mode), .clamp_off(clamp_off), .blank_to_clamp(blank_to_clamp),
        .pol_sample(pol_sample), .pol_dclk(pol_dclk), .pol_clamp(pol_clamp),
        .pol_blank(pol_blank), .out_hiz(out_hiz), .latch_transparent(latch_transparent),
        .gray_out(gray_out), .clamp_level(clamp_level), .vga_gain(vga_gain));

    function automatic logic [28:0] exp_vec();
        return {mreg[0][2:1], mreg[0][3], mreg[0][6], mreg[1][6:0], mreg[2][7:0], mreg[3][9:0]};
    endfunction
    function automatic logic [28:0] act_vec();
        return {pwr_mode, clamp_off, blank_to_clamp, gray_out, latch_transparent, out_hiz,
                pol_blank, pol_clamp, pol_dclk, pol_sample, clamp_level, vga_gain};
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 4; i++) begin
            mreg[i] = (i == 2) ? 12'd128 : 12'd0;
            mpd[i] = 0;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference model
    always @(negedge clk) if (checking && !done) check(cur_req, 32'(act_vec()), 32'(exp_vec()));

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        sdata = b; sck = 1'b0; tick(3);
        sck = 1'b1; tick(3);
    endtask

    task automatic run_frame(logic [2:0] a, logic guard, bit accept, int extra);
        int ma = a;
        sl = 1'b0; tick(4);
        for (int k = 0; k < 3; k++) send_bit(a[k]);
        send_bit(guard);
        foreach (wq[j]) begin
            for (int k = 0; k < 12; k++) send_bit(wq[j][k]);
            if (accept && !guard && ma < 4) begin msh[ma] = wq[j]; mpd[ma] = 1; end
            ma = (ma + 1) % 8;
        end
        for (int k = 0; k < extra; k++) send_bit(1'b1);
        sck = 1'b0; tick(3);
        sl = 1'b1;
        repeat (3) @(posedge clk);
        if (mpd[0] && msh[0][0]) model_defaults();
        else for (int i = 0; i < 4; i++) begin
            if (mpd[i]) mreg[i] = msh[i];
            mpd[i] = 0;
        end
        tick(6);
        wq.delete();
    endtask

    task automatic report();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        model_defaults();
        tick(5);
        rst_n = 1'b1;
        checking = 1;
        tick(1);
        check("R1", 32'(clamp_level), 32'd128);
        check("R1", 32'(vga_gain), 32'd0);

        cur_req = "R11";
        wq.push_back(12'h155);
        run_frame(3'd3, 1'b0, 0, 0);
        check("R11", 32'(vga_gain), 32'd0);
        tick(CAL + 50);

        cur_req = "R2";
        wq.push_back(12'h03C);
        run_frame(3'd2, 1'b0, 1, 0);
        check("R2", 32'(clamp_level), 32'h3C);

        cur_req = "R3";
        wq.push_back(12'h04A); wq.push_back(12'h055);
        wq.push_back(12'h0A5); wq.push_back(12'h3FF);
        run_frame(3'd0, 1'b0, 1, 0);
        check("R3", 32'(pwr_mode), 32'd1);
        check("R3", 32'({clamp_off, blank_to_clamp}), 32'b11);
        check("R4", 32'({gray_out, latch_transparent, out_hiz, pol_blank, pol_clamp, pol_dclk, pol_sample}), 32'h55);
        check("R5", 32'(vga_gain), 32'h3FF);

        cur_req = "R7";
        wq.push_back(12'hFFF); wq.push_back(12'hFFF);
        wq.push_back(12'h004); wq.push_back(12'h02A);
        run_frame(3'd6, 1'b0, 1, 0);
        check("R7", 32'(pwr_mode), 32'd2);
        check("R7", 32'(clamp_level), 32'hA5);

        cur_req = "R8";
        wq.push_back(12'h001);
        run_frame(3'd3, 1'b1, 1, 0);
        check("R8", 32'(vga_gain), 32'h3FF);

        cur_req = "R9";
        wq.push_back(12'h011);
        run_frame(3'd2, 1'b0, 1, 5);
        check("R9", 32'(clamp_level), 32'h11);
        check("R9", 32'(vga_gain), 32'h3FF);

        cur_req = "R10";
        wq.push_back(12'h001); wq.push_back(12'h07F);
        run_frame(3'd0, 1'b0, 1, 0);
        check("R10", 32'(clamp_level), 32'd128);
        check("R10", 32'({gray_out, pol_sample}), 32'd0);

        cur_req = "R5";
        wq.push_back(12'h200);
        run_frame(3'd3, 1'b0, 1, 0);
        check("R5", 32'(vga_gain), 32'h200);
        check("R6", 32'(act_vec()), 32'(exp_vec()));

        report();
    end
endmodule